// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Sequencer

This block sits on the processor side of a local bus. When a level-sensitive interrupt request is present and the interrupt-enable flag is set, it runs two locked interrupt-acknowledge bus cycles. An external interrupt controller decodes these cycles and returns a service vector on the low byte of the data bus at the end of the second cycle. The block captures that byte and presents it for one clock together with a valid strobe.

Each acknowledge cycle opens with a one-clock address strobe. It then waits until ready is sampled low. A parameterised run of idle bus clocks, never fewer than four, separates the two cycles so that a slow controller has time to recover. The bus lock is held over both cycles and over the gap between them. Bus hold requests from other masters are granted only when no sequence is running. While a hold is granted, interrupt requests are not sampled. After a vector is delivered, the enable flag must be seen low and then set again before another request is accepted.

Top module: `intack_seq`

## Requirements
- R1: From idle, with no hold granted, if irq_req, irq_en and the internal re-arm flag (set at reset) are all high at a clock edge, the first acknowledge cycle starts and ads_n is low in the very next clock.
- R2: In each acknowledge cycle ads_n is low for exactly one clock. The following clocks are wait clocks for as long as rdy_n is sampled high, and the cycle ends at the first of them in which rdy_n is sampled low.
- R3: The three status lines {st_mem, st_data, st_write} are all 0 throughout both acknowledge cycles and all 1 when the bus is idle.
- R4: lock_n is low from the first clock of the first cycle through the terminating clock of the second cycle, including the gap, and is high in the clock after completion.
- R5: The first cycle drives addr = 4 and the second drives addr = 0. be_n = 4'b1110 (only byte lane 0 enabled) in both cycles. When no cycle is running, addr is 0 and be_n is 4'b1111.
- R6: After the first cycle ends, ads_n stays high for exactly GAP_LEN clocks (GAP_LEN is clamped to at least 4). ads_n then goes low for the second cycle with addr = 0.
- R7: data_in is captured at the clock edge where the second cycle ends. In the next clock vec_valid is 1 and vec_out holds that byte, and vec_valid is 0 in the clock after that.
- R8: A hold_req raised during the sequence keeps hold_ack at 0 until completion. hold_ack rises in the clock after the vec_valid clock.
- R9: In idle, hold_ack follows hold_req with a one-clock delay. While hold_ack is 1, irq_req is ignored. After hold_req drops, hold_ack falls one clock later, and a pending request starts a cycle one clock after that.
- R10: After a vector is delivered, irq_req with irq_en held high starts no new cycle. A new sequence starts only after irq_en has been sampled 0 and then 1.
- R11: dbus_float is 1 in every clock of both acknowledge cycles and while hold_ack is 1. It is 0 in idle and in the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 1 | Level-sensitive interrupt request |
| irq_en | input | 1 | Interrupt-enable flag |
| rdy_n | input | 1 | Active-low cycle-terminate ready |
| hold_req | input | 1 | Bus request from another master |
| data_in | input | 8 | Low byte of the data bus |
| ads_n | output | 1 | Active-low address strobe |
| st_mem | output | 1 | Memory/IO status line |
| st_data | output | 1 | Data/control status line |
| st_write | output | 1 | Write/read status line |
| be_n | output | 4 | Active-low byte enables |
| addr | output | ADDR_W | Bus address |
| lock_n | output | 1 | Active-low bus lock |
| hold_ack | output | 1 | Hold grant |
| dbus_float | output | 1 | Data bus released (not driven) |
| vec_valid | output | 1 | One-clock vector valid pulse |
| vec_out | output | 8 | Captured service vector |

## Verification
The acknowledge pair is run four ways. The first run has no wait clocks, which pins the gap length and the exact clock of each strobe. The second has several wait clocks in each cycle, which separates termination on ready from termination on a fixed count. The third raises a hold request in the middle of the pair, which shows that the grant waits for the pair to finish. The fourth starts from a granted hold, which shows that the request is ignored until the hold is released. A run with the enable flag low and a repeated request after a completed pair tell apart the start qualification and the re-arm rule. Distinct vector bytes in each run confirm that capture happens on the terminating clock.

// File: rtl/intack_pkg.sv
package intack_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_T1A  = 3'd1,
        S_T2A  = 3'd2,
        S_GAP  = 3'd3,
        S_T1B  = 3'd4,
        S_T2B  = 3'd5
    } seq_st_e;

    typedef struct packed {
        seq_st_e     state;
        logic        armed;
        logic        hold_ack;
        logic        vec_valid;
        logic [7:0]  vec;
    } seq_regs_t;

endpackage

// File: rtl/intack_gap_timer.sv
module intack_gap_timer #(
    parameter int GAP_EFF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic in_gap,
    output logic done
);
    localparam int CW = $clog2(GAP_EFF + 1);
    localparam logic [CW-1:0] LOAD = CW'(GAP_EFF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = LOAD;
        else if (in_gap && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = in_gap && (cnt_q == '0);

    // R6
    gap_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD);

    // R6
    gap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == LOAD));

endmodule

// File: rtl/intack_bus_enc.sv
module intack_bus_enc
    import intack_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] FIRST_ADDR  = ADDR_W'(4),
    parameter logic [ADDR_W-1:0] SECOND_ADDR = ADDR_W'(0)
) (
    input  seq_st_e           state,
    input  logic              hold_ack,
    output logic              ads_n,
    output logic              st_mem,
    output logic              st_data,
    output logic              st_write,
    output logic [3:0]        be_n,
    output logic [ADDR_W-1:0] addr,
    output logic              lock_n,
    output logic              dbus_float
);
    logic in_c1, in_c2, in_cyc;

    always_comb begin
        in_c1  = (state == S_T1A) || (state == S_T2A);
        in_c2  = (state == S_T1B) || (state == S_T2B);
        in_cyc = in_c1 || in_c2;
        ads_n  = !((state == S_T1A) || (state == S_T1B));
        st_mem   = !in_cyc;
        st_data  = !in_cyc;
        st_write = !in_cyc;
        be_n   = in_cyc ? 4'b1110 : 4'b1111;
        lock_n = (state == S_IDLE);
        dbus_float = in_cyc || hold_ack;
    end

    for (genvar i = 0; i < ADDR_W; i++) begin : g_addr
        assign addr[i] = in_c1 ? FIRST_ADDR[i] : (in_c2 ? SECOND_ADDR[i] : 1'b0);
    end

endmodule

// File: rtl/intack_fsm.sv
module intack_fsm
    import intack_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_req,
    input  logic       irq_en,
    input  logic       rdy_n,
    input  logic       hold_req,
    input  logic [7:0] data_in,
    input  logic       gap_done,
    output logic       gap_start,
    output seq_st_e    state,
    output logic       hold_ack,
    output logic       vec_valid,
    output logic [7:0] vec_out
);
    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        r_d.vec_valid = 1'b0;
        gap_start = 1'b0;
        if (!irq_en)
            r_d.armed = 1'b1;
        unique case (r_q.state)
            S_IDLE: begin
                if (r_q.hold_ack) begin
                    r_d.hold_ack = hold_req;
                end else if (irq_req && irq_en && r_q.armed) begin
                    r_d.state    = S_T1A;
                    r_d.hold_ack = 1'b0;
                end else begin
                    r_d.hold_ack = hold_req;
                end
            end
            S_T1A: r_d.state = S_T2A;
            S_T2A: begin
                if (!rdy_n) begin
                    r_d.state = S_GAP;
                    gap_start = 1'b1;
                end
            end
            S_GAP: begin
                if (gap_done) r_d.state = S_T1B;
            end
            S_T1B: r_d.state = S_T2B;
            S_T2B: begin
                if (!rdy_n) begin
                    r_d.state     = S_IDLE;
                    r_d.vec       = data_in;
                    r_d.vec_valid = 1'b1;
                    r_d.armed     = 1'b0;
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state     <= S_IDLE;
            r_q.armed     <= 1'b1;
            r_q.hold_ack  <= 1'b0;
            r_q.vec_valid <= 1'b0;
            r_q.vec       <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state     = r_q.state;
    assign hold_ack  = r_q.hold_ack;
    assign vec_valid = r_q.vec_valid;
    assign vec_out   = r_q.vec;

    // R8
    hold_idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ack |-> (state == S_IDLE));

    // R6
    gap_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_GAP && !gap_done) |=> (state == S_GAP));

endmodule

// File: rtl/intack_seq.sv
module intack_seq
    import intack_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int GAP_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic              irq_en,
    input  logic              rdy_n,
    input  logic              hold_req,
    input  logic [7:0]        data_in,
    output logic              ads_n,
    output logic              st_mem,
    output logic              st_data,
    output logic              st_write,
    output logic [3:0]        be_n,
    output logic [ADDR_W-1:0] addr,
    output logic              lock_n,
    output logic              hold_ack,
    output logic              dbus_float,
    output logic              vec_valid,
    output logic [7:0]        vec_out
);
    localparam int GAP_EFF = (GAP_LEN < 4) ? 4 : GAP_LEN;
    localparam logic [ADDR_W-1:0] ADDR_FIRST = ADDR_W'(4);

    seq_st_e state;
    logic    gap_start, gap_done, in_gap;

    assign in_gap = (state == S_GAP);

    intack_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
        .rdy_n(rdy_n), .hold_req(hold_req), .data_in(data_in),
        .gap_done(gap_done), .gap_start(gap_start), .state(state),
        .hold_ack(hold_ack), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    intack_gap_timer #(.GAP_EFF(GAP_EFF)) u_gap (
        .clk(clk), .rst_n(rst_n), .start(gap_start), .in_gap(in_gap),
        .done(gap_done)
    );

    intack_bus_enc #(
        .ADDR_W(ADDR_W), .FIRST_ADDR(ADDR_FIRST), .SECOND_ADDR(ADDR_W'(0))
    ) u_enc (
        .state(state), .hold_ack(hold_ack), .ads_n(ads_n), .st_mem(st_mem),
        .st_data(st_data), .st_write(st_write), .be_n(be_n), .addr(addr),
        .lock_n(lock_n), .dbus_float(dbus_float)
    );

    // R2
    strobe_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |=> ads_n);

    // R5
    strobe_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |-> (be_n == 4'b1110));

    // R4
    lock_starts_c1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> (!ads_n && addr == ADDR_FIRST));

    // R8
    no_hold_in_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_n |-> !hold_ack);

    // R7
    vec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    // R7
    vec_at_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $rose(lock_n));

    // R3
    status_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ads_n |-> (!st_mem && !st_data && !st_write));

endmodule

// File: tb/intack_seq_test.sv
`timescale 1ns/1ps
module intack_seq_test;
    localparam int GAP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_req = 1'b0, irq_en = 1'b0, rdy_n = 1'b1, hold_req = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic ads_n, st_mem, st_data, st_write, lock_n, hold_ack, dbus_float, vec_valid;
    logic [3:0] be_n;
    logic [31:0] addr;
    logic [7:0] vec_out;

    int n_checks = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    intack_seq #(.ADDR_W(32), .GAP_LEN(GAP)) uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en),
        .rdy_n(rdy_n), .hold_req(hold_req), .data_in(data_in),
        .ads_n(ads_n), .st_mem(st_mem), .st_data(st_data), .st_write(st_write),
        .be_n(be_n), .addr(addr), .lock_n(lock_n), .hold_ack(hold_ack),
        .dbus_float(dbus_float), .vec_valid(vec_valid), .vec_out(vec_out)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Called at the negedge of the first clock of cycle 1 (strobe low).
    task automatic finish_pair(input int w1, input int w2, input logic [7:0] v,
                               input bit hold_mid);
        chk("R2 strobe cycle1", ads_n, 0);
        chk("R5 addr cycle1", addr, 4);
        chk("R5 be cycle1", be_n, 4'hE);
        chk("R3 status cycle1", {st_mem, st_data, st_write}, 0);
        chk("R4 lock cycle1", lock_n, 0);
        chk("R11 float cycle1", dbus_float, 1);
        if (hold_mid) hold_req = 1'b1;
        tick();
        for (int i = 0; i < w1; i++) begin
            chk("R2 wait cycle1", ads_n, 1);
            chk("R5 addr wait cycle1", addr, 4);
            chk("R3 status wait", {st_mem, st_data, st_write}, 0);
            chk("R8 no hold cycle1", hold_ack, 0);
            tick();
        end
        chk("R2 t2 cycle1", ads_n, 1);
        rdy_n = 1'b0;
        tick();
        rdy_n = 1'b1;
        for (int g = 0; g < GAP; g++) begin
            chk("R6 gap idle", ads_n, 1);
            chk("R4 lock gap", lock_n, 0);
            chk("R11 float gap", dbus_float, 0);
            chk("R8 no hold gap", hold_ack, 0);
            tick();
        end
        chk("R6 strobe cycle2", ads_n, 0);
        chk("R5 addr cycle2", addr, 0);
        chk("R5 be cycle2", be_n, 4'hE);
        chk("R3 status cycle2", {st_mem, st_data, st_write}, 0);
        chk("R4 lock cycle2", lock_n, 0);
        chk("R11 float cycle2", dbus_float, 1);
        irq_req = 1'b0;
        tick();
        for (int i = 0; i < w2; i++) begin
            chk("R2 wait cycle2", ads_n, 1);
            chk("R4 lock wait cycle2", lock_n, 0);
            chk("R7 no early vector", vec_valid, 0);
            tick();
        end
        data_in = v;
        rdy_n = 1'b0;
        tick();
        rdy_n = 1'b1;
        data_in = 8'h00;
        chk("R7 vector valid", vec_valid, 1);
        chk("R7 vector value", vec_out, v);
        chk("R4 lock released", lock_n, 1);
        chk("R8 hold still deferred", hold_ack, 0);
        chk("R3 status idle", {st_mem, st_data, st_write}, 3'b111);
        chk("R5 be idle", be_n, 4'hF);
        tick();
        chk("R7 vector pulse ends", vec_valid, 0);
        chk("R1 no third cycle", ads_n, 1);
        if (hold_mid) begin
            chk("R8 hold granted after pair", hold_ack, 1);
            hold_req = 1'b0;
            tick();
            chk("R8 hold released", hold_ack, 0);
        end
    endtask

    task automatic run_ack(input int w1, input int w2, input logic [7:0] v,
                           input bit hold_mid);
        irq_en = 1'b0;
        irq_req = 1'b0;
        tick();
        irq_req = 1'b1;
        irq_en = 1'b1;
        tick();
        finish_pair(w1, w2, v, hold_mid);
    endtask

    task automatic t_reset();
        chk("R1 reset strobe", ads_n, 1);
        chk("R4 reset lock", lock_n, 1);
        chk("R5 reset addr", addr, 0);
        chk("R5 reset be", be_n, 4'hF);
        chk("R8 reset hold", hold_ack, 0);
        chk("R7 reset valid", vec_valid, 0);
        chk("R11 reset float", dbus_float, 0);
    endtask

    task automatic t_disabled();
        irq_req = 1'b1;
        irq_en = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R1 disabled no strobe", ads_n, 1);
        end
        irq_req = 1'b0;
    endtask

    task automatic t_rearm();
        run_ack(0, 0, 8'h3C, 1'b0);
        irq_req = 1'b1;
        irq_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R10 ignored until rearm", ads_n, 1);
        end
        irq_en = 1'b0;
        tick();
        chk("R10 enable low no start", ads_n, 1);
        irq_en = 1'b1;
        tick();
        finish_pair(1, 1, 8'hE7, 1'b0);
    endtask

    task automatic t_hold_idle();
        irq_en = 1'b0;
        tick();
        hold_req = 1'b1;
        tick();
        chk("R9 hold granted", hold_ack, 1);
        chk("R11 float on hold", dbus_float, 1);
        irq_req = 1'b1;
        irq_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R9 irq ignored in hold", ads_n, 1);
            chk("R9 hold kept", hold_ack, 1);
        end
        hold_req = 1'b0;
        tick();
        chk("R9 hold dropped", hold_ack, 0);
        chk("R9 no start same clock", ads_n, 1);
        tick();
        finish_pair(0, 2, 8'h99, 1'b0);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        tick();
        tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_disabled();
        run_ack(0, 0, 8'h5A, 1'b0);
        run_ack(3, 2, 8'hC3, 1'b0);
        run_ack(1, 0, 8'h81, 1'b1);
        t_rearm();
        t_hold_idle();
        tick();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule